// File: doc/BRIEF.md
# Timer with Capture/Compare Channel and Selectable Polarity

This block is a 16-bit up-counting timer with one channel that can work either as an input capture or as a compare output. The counter runs from zero up to a programmable reload value and then returns to zero. Each return to zero raises an update flag, which software clears by writing zero to it. A read of the counter register also returns that flag in its most significant bit, so software can fetch the count and the overflow state in one access.

In input mode, the channel passes an external signal through a two-flop synchronizer. A two-bit polarity code selects whether a rising edge, a falling edge or either edge copies the current count into the channel register and raises a capture flag. In output mode, the channel compares the count with the channel register. The reference is high while the count is below that value. The polarity bit can invert it. An output-enable signal tells the pad driver whether to drive the pin or leave it high-impedance.

All state is reached through a single-cycle register bus. Writes take effect at the next clock edge. Reads are combinational from the address.

Top module: `tmr_capcmp`

## Requirements
- R1: After reset the count is 0, the reload value is 0xFFFF, the channel register is 0, the control and status registers read 0, and `cc_oe_o` is 0.
- R2: The counter register at address 0x24 takes bits 15:0 of a write. While the run bit is set, the count rises by one on every clock edge on which the counter is not written.
- R3: When the count equals the reload value (address 0x2C) and the run bit is set, the next count is 0 and the update flag (status bit 0, address 0x10) is set. Writing status bit 0 as 0 clears the flag. Writing it as 1 leaves the flag unchanged.
- R4: A read of address 0x24 returns the update flag in bit 31, zeros in bits 30:16 and the count in bits 15:0.
- R5: The control register at address 0x00 holds bit 0 channel enable, bit 1 polarity P, bit 2 polarity NP, bit 3 mode (1 = output, 0 = input) and bit 4 run. It reads back the value written to those bits.
- R6: In input mode, changes on `cap_in_i` are seen through a two-flop synchronizer. The code {NP,P} = 00 captures on rising edges only, 01 on falling edges only and 11 on both edges. The code 10 captures on no edge.
- R7: A capture copies the current count into the channel register (address 0x34) and sets the capture flag (status bit 1). Writing status bit 1 as 0 clears the flag.
- R8: A capture happens only when the channel enable is 1 and the mode is input. Otherwise an input edge leaves the channel register and the capture flag unchanged.
- R9: `cc_o` equals (count < channel register) XOR P.
- R10: `cc_oe_o` is 1 exactly when the channel enable is 1 and the mode is output. When it is 0, the pad driver leaves the pin high-impedance.
- R11: The reload register at address 0x2C is readable and writable in bits 15:0. Addresses outside the map read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| cap_in_i | input | 1 | Asynchronous capture input |
| cc_o | output | 1 | Compare output level after polarity |
| cc_oe_o | output | 1 | Pad drive enable; 0 releases the pin |

## Verification
The capture logic is driven through every combination of the four polarity codes, a rising or a falling input transition, and the enable bit. Before each trial the count is frozen at a distinct value, so the channel register shows both whether a capture happened and which trial it came from. This separates the rising, falling, both-edge and reserved codes, and it shows that the enable gates capture. The compare output is swept over every count from 0 to 16, against channel values of 0, 5 and 15 and with both polarities, which exposes off-by-one errors at the compare threshold and inversion errors. Counting is stepped an exact number of clocks across a small reload value to pin down the wrap point, the update flag, the bit-31 copy and the write-zero clearing rule.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 8'h24;
  localparam logic [ADDR_W-1:0] ADDR_ARR  = 8'h2C;
  localparam logic [ADDR_W-1:0] ADDR_CCR  = 8'h34;

  // control register, bit 4 down to bit 0
  typedef struct packed {
    logic run;
    logic out_mode;
    logic pol_n;
    logic pol;
    logic ch_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    EDGE_NONE,
    EDGE_RISE,
    EDGE_FALL,
    EDGE_BOTH
  } edge_sel_e;

  function automatic edge_sel_e decode_edge(logic pol_n, logic pol);
    case ({pol_n, pol})
      2'b00:   return EDGE_RISE;
      2'b01:   return EDGE_FALL;
      2'b11:   return EDGE_BOTH;
      default: return EDGE_NONE;  // reserved code
    endcase
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = run_i && !wr_i && (cnt_q == arr_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_i)    cnt_q <= wdata_i;
    else if (wrap_o)  cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_i,
  input  tmr_pkg::edge_sel_e  edge_sel_i,
  input  logic                arm_i,
  output logic                fire_o
);
  import tmr_pkg::*;

  // sync chain plus one history flop for edge detection
  logic [SYNC_STAGES:0] sh_q;
  logic cur, prev, rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], in_i};
  end

  assign cur  = sh_q[SYNC_STAGES-1];
  assign prev = sh_q[SYNC_STAGES];
  assign rise = cur && !prev;
  assign fall = !cur && prev;

  always_comb begin
    case (edge_sel_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise || fall;
      default:   hit = 1'b0;
    endcase
  end

  assign fire_o = arm_i && hit;
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             pol_i,
  input  logic             ch_en_i,
  input  logic             out_mode_i,
  output logic             ref_o,
  output logic             cc_o,
  output logic             cc_oe_o
);
  assign ref_o   = cnt_i < cmp_i;
  assign cc_o    = ref_o ^ pol_i;
  assign cc_oe_o = ch_en_i && out_mode_i;
endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp #(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [tmr_pkg::ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic                      cap_in_i,
  output logic                      cc_o,
  output logic                      cc_oe_o
);
  import tmr_pkg::*;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] arr_q, ccr_q, cnt;
  logic             uf_q, cf_q;
  logic             wr_ctrl, wr_stat, wr_cnt, wr_arr, wr_ccr;
  logic             wrap, cap_fire, cmp_ref;
  edge_sel_e        edge_sel;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_stat = wr_en_i && (addr_i == ADDR_STAT);
  assign wr_cnt  = wr_en_i && (addr_i == ADDR_CNT);
  assign wr_arr  = wr_en_i && (addr_i == ADDR_ARR);
  assign wr_ccr  = wr_en_i && (addr_i == ADDR_CCR);

  assign edge_sel = decode_edge(ctrl_q.pol_n, ctrl_q.pol);

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (ctrl_q.run),
    .wr_i    (wr_cnt),
    .wdata_i (wdata_i[CNT_W-1:0]),
    .arr_i   (arr_q),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  tmr_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_i       (cap_in_i),
    .edge_sel_i (edge_sel),
    .arm_i      (ctrl_q.ch_en && !ctrl_q.out_mode),
    .fire_o     (cap_fire)
  );

  tmr_compare #(.CNT_W(CNT_W)) u_cmp (
    .cnt_i      (cnt),
    .cmp_i      (ccr_q),
    .pol_i      (ctrl_q.pol),
    .ch_en_i    (ctrl_q.ch_en),
    .out_mode_i (ctrl_q.out_mode),
    .ref_o      (cmp_ref),
    .cc_o       (cc_o),
    .cc_oe_o    (cc_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      arr_q  <= '1;
      ccr_q  <= '0;
      uf_q   <= 1'b0;
      cf_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_arr)  arr_q  <= wdata_i[CNT_W-1:0];
      // a capture wins over a bus write in the same cycle
      if (cap_fire)    ccr_q <= cnt;
      else if (wr_ccr) ccr_q <= wdata_i[CNT_W-1:0];
      // flag set wins over a write-zero clear
      if (wrap)                     uf_q <= 1'b1;
      else if (wr_stat && !wdata_i[0]) uf_q <= 1'b0;
      if (cap_fire)                 cf_q <= 1'b1;
      else if (wr_stat && !wdata_i[1]) cf_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      ADDR_STAT: rdata_o[1:0]        = {cf_q, uf_q};
      ADDR_CNT: begin
        rdata_o[CNT_W-1:0] = cnt;
        rdata_o[DATA_W-1]  = uf_q;
      end
      ADDR_ARR:  rdata_o[CNT_W-1:0]  = arr_q;
      ADDR_CCR:  rdata_o[CNT_W-1:0]  = ccr_q;
      default:   rdata_o = '0;
    endcase
  end

  logic unused_ref;
  assign unused_ref = cmp_ref;
endmodule

// File: rtl/tmr_capcmp_chk.sv
module tmr_capcmp_chk #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic [tmr_pkg::ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0]          rdata_o,
  input logic                       cc_o,
  input logic                       cc_oe_o,
  input tmr_pkg::ctrl_t             ctrl_i,
  input logic [CNT_W-1:0]           cnt_i,
  input logic [CNT_W-1:0]           arr_i,
  input logic [CNT_W-1:0]           ccr_i,
  input logic                       uf_i,
  input logic                       cf_i,
  input logic                       cap_fire_i
);
  import tmr_pkg::*;

  logic cnt_wr;
  assign cnt_wr = wr_en_i && (addr_i == ADDR_CNT);

  assert_run_increment_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.run && !cnt_wr && cnt_i != arr_i) |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  assert_wrap_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.run && !cnt_wr && cnt_i == arr_i) |=> (cnt_i == '0 && uf_i));

  assert_cnt_readback_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CNT) |-> (rdata_o[DATA_W-2:CNT_W] == '0 && rdata_o[DATA_W-1] == uf_i));

  assert_reserved_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.pol_n && !ctrl_i.pol) |-> !cap_fire_i);

  assert_capture_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_fire_i |=> (ccr_i == $past(cnt_i) && cf_i));

  assert_capture_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.ch_en || ctrl_i.out_mode) |-> !cap_fire_i);

  assert_polarity_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_oe_o |-> (cc_o == ((cnt_i < ccr_i) ^ ctrl_i.pol)));

  assert_oe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_oe_o == (ctrl_i.ch_en && ctrl_i.out_mode));
endmodule

bind tmr_capcmp tmr_capcmp_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .cc_o       (cc_o),
  .cc_oe_o    (cc_oe_o),
  .ctrl_i     (ctrl_q),
  .cnt_i      (cnt),
  .arr_i      (arr_q),
  .ccr_i      (ccr_q),
  .uf_i       (uf_q),
  .cf_i       (cf_q),
  .cap_fire_i (cap_fire)
);

// File: tb/tb_tmr_capcmp.sv
`timescale 1ns/1ps
module tb_tmr_capcmp;
  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h10, A_CNT = 8'h24,
                         A_ARR = 8'h2C, A_CCR = 8'h34, A_NONE = 8'h08;
  localparam logic [31:0] C_EN = 32'h1, C_P = 32'h2, C_NP = 32'h4,
                          C_OUT = 32'h8, C_RUN = 32'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cap_in = 1'b0;
  logic        cc, cc_oe;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  tmr_capcmp dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_in_i(cap_in),
    .cc_o(cc), .cc_oe_o(cc_oe)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // run the counter for exactly n clock edges
  task automatic run_cycles(input int n, input logic [31:0] base);
    wr(A_CTRL, base | C_RUN);
    repeat (n - 1) @(posedge clk);
    wr(A_CTRL, base);
  endtask

  function automatic bit exp_cap(input int code, input bit rising);
    case (code)
      0: return rising;
      1: return !rising;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL R1 watchdog got running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); check("R1 stat", d, 32'h0);
    rd(A_CNT, d);  check("R1 cnt", d, 32'h0);
    rd(A_ARR, d);  check("R1 arr", d, 32'h0000FFFF);
    rd(A_CCR, d);  check("R1 ccr", d, 32'h0);
    check("R1 oe", {31'b0, cc_oe}, 32'h0);

    // R5 control readback
    wr(A_CTRL, 32'h0F); rd(A_CTRL, d); check("R5 ctrl 0F", d, 32'h0F);
    wr(A_CTRL, 32'h05); rd(A_CTRL, d); check("R5 ctrl 05", d, 32'h05);
    wr(A_CTRL, 32'h0);

    // R11 reload access and unmapped reads
    wr(A_ARR, 32'hFFFF1234); rd(A_ARR, d); check("R11 arr", d, 32'h1234);
    rd(A_NONE, d); check("R11 unmapped", d, 32'h0);

    // R2 load and count
    wr(A_ARR, 32'hFFFF);
    wr(A_CNT, 32'd100); rd(A_CNT, d); check("R2 load", d, 32'd100);
    run_cycles(7, 0); rd(A_CNT, d); check("R2 run7", d, 32'd107);
    run_cycles(1, 0); rd(A_CNT, d); check("R2 run1", d, 32'd108);
    rd(A_STAT, d); check("R3 no wrap", d, 32'h0);

    // R3/R4 wrap at reload value
    wr(A_ARR, 32'd10); wr(A_CNT, 32'd8);
    run_cycles(2, 0); rd(A_STAT, d); check("R3 before wrap", d, 32'h0);
    run_cycles(1, 0); rd(A_CNT, d); check("R3 R4 wrap zero", d, 32'h80000000);
    run_cycles(2, 0); rd(A_CNT, d); check("R4 cnt with flag", d, 32'h80000002);
    rd(A_STAT, d); check("R3 flag set", d, 32'h1);
    wr(A_STAT, 32'h1); rd(A_STAT, d); check("R3 write one keeps", d, 32'h1);
    wr(A_CNT, 32'hABCD1234); rd(A_CNT, d); check("R4 upper write ignored", d, 32'h80001234);
    wr(A_STAT, 32'h2); rd(A_STAT, d); check("R3 write zero clears", d, 32'h0);
    rd(A_CNT, d); check("R4 cnt no flag", d, 32'h00001234);
    wr(A_ARR, 32'hFFFF);

    // R6/R7/R8 capture sweep: code x edge x enable
    for (int code = 0; code < 4; code++) begin
      for (int rising = 0; rising < 2; rising++) begin
        for (int en = 0; en < 2; en++) begin
          logic [31:0] cfg, v;
          bit hit;
          cfg = (en != 0 ? C_EN : 0) | (code[0] ? C_P : 0) | (code[1] ? C_NP : 0);
          v = 32'h100 + code * 16 + rising * 4 + en;
          wr(A_CTRL, 32'h0);
          @(negedge clk) cap_in = (rising == 0);
          repeat (5) @(posedge clk);
          wr(A_STAT, 32'h0); wr(A_CCR, 32'h0); wr(A_CNT, v);
          wr(A_CTRL, cfg);
          @(negedge clk) cap_in = (rising != 0);
          repeat (5) @(posedge clk);
          hit = (en != 0) && exp_cap(code, rising != 0);
          rd(A_CCR, d); check($sformatf("R6 R7 R8 ccr code%0d rise%0d en%0d", code, rising, en),
                               d, hit ? v : 32'h0);
          rd(A_STAT, d); check($sformatf("R7 flag code%0d rise%0d en%0d", code, rising, en),
                                d & 32'h2, hit ? 32'h2 : 32'h0);
        end
      end
    end
    wr(A_STAT, 32'h1); rd(A_STAT, d); check("R7 flag clear", d, 32'h0);

    // R8 output mode blocks capture
    wr(A_CTRL, 32'h0);
    @(negedge clk) cap_in = 1'b0;
    repeat (5) @(posedge clk);
    wr(A_CCR, 32'h0); wr(A_CNT, 32'h55);
    wr(A_CTRL, C_EN | C_OUT);
    @(negedge clk) cap_in = 1'b1;
    repeat (5) @(posedge clk);
    rd(A_CCR, d); check("R8 out mode ccr", d, 32'h0);
    rd(A_STAT, d); check("R8 out mode flag", d, 32'h0);

    // R9/R10 compare sweep
    for (int p = 0; p < 2; p++) begin
      foreach (d[i]) begin end
      for (int ci = 0; ci < 3; ci++) begin
        logic [15:0] cv;
        cv = (ci == 0) ? 16'd0 : (ci == 1) ? 16'd5 : 16'd15;
        wr(A_CTRL, C_EN | C_OUT | (p != 0 ? C_P : 0));
        wr(A_CCR, {16'h0, cv});
        for (int c = 0; c <= 16; c++) begin
          bit e;
          wr(A_CNT, c);
          e = (c < cv) ^ (p != 0);
          check($sformatf("R9 cc cnt%0d ccr%0d p%0d", c, cv, p), {31'b0, cc}, {31'b0, e});
        end
        check("R10 oe on", {31'b0, cc_oe}, 32'h1);
      end
    end

    // R10 enable gating
    wr(A_CTRL, C_OUT); check("R10 oe off en0", {31'b0, cc_oe}, 32'h0);
    wr(A_CTRL, C_EN);  check("R10 oe off input", {31'b0, cc_oe}, 32'h0);
    wr(A_CTRL, C_EN | C_OUT | C_NP); check("R10 oe np ignored", {31'b0, cc_oe}, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule